// File: doc/BRIEF.md
# Host-to-controller command mailbox

This block is the register window through which a host processor hands a command to an embedded power-management controller and later collects the outcome. On its host side it is a plain 32-bit register bus with a write strobe and a combinational read path. The host loads two pointer words and a 16-byte outbound data buffer, then writes a command word. That write alone starts a transaction. Busy goes up, and a request is raised toward the controller-side responder.

The responder sees the latched command, the pointers and the outbound buffer. It may fill the 16-byte inbound buffer while its request is outstanding. It finishes with a one-cycle done pulse that carries an error flag and an 8-bit error code. Busy then drops, and the host reads the status word and the inbound buffer. When bit 8 of the command word was set, completion also raises a level-sensitive host interrupt. The host acknowledges it by writing status with bit 2 set. When bit 8 was clear, the host polls busy instead.

Top module: `mbox_ipc`

## Requirements
- R1: After reset every register and buffer reads zero, busy is clear, `rsp_req` is low, and `irq_o` and `ovf_o` are low.
- R2: An aligned host write to offset 0x00 while idle makes busy and `rsp_req` high from the next cycle. The written word is latched, presented on `rsp_cmd` and read back at 0x00. No other write raises `rsp_req`.
- R3: A command write while busy is dropped, leaving `rsp_cmd` unchanged. It sets `ovf_o`, which stays high until reset.
- R4: The pointer words at 0x08 (`rsp_sptr`) and 0x0C (`rsp_dptr`) and the outbound words at 0x80, 0x84, 0x88 and 0x8C (`rsp_obuf` word 0 to 3, word 0 in the low bits) are written by the host and read back. Host writes to them are ignored while busy.
- R5: The inbound words at 0x90 to 0x9C are written only by the responder (`rsp_wr_idx` selects word 0 to 3), and only while `rsp_req` is high. Host writes there and responder writes while idle have no effect.
- R6: A `rsp_done` pulse while `rsp_req` is high clears busy and `rsp_req` from the next cycle and captures `rsp_err`. It captures `rsp_code` only when `rsp_err` is 1 and stores zero otherwise. A `rsp_done` pulse while idle changes nothing.
- R7: The status word at 0x04 carries busy in bit 0, the error flag in bit 1, interrupt-pending in bit 2 and the error code in bits 23:16. All other bits read 0. Host writes to bits 0, 1 and 23:16 have no effect.
- R8: Completion of a command whose bit 8 was 1 sets interrupt-pending. Completion of a command whose bit 8 was 0 leaves it unchanged. `irq_o` always equals interrupt-pending.
- R9: A status write with bit 2 set clears interrupt-pending, and a status write with bit 2 clear leaves it unchanged. When such a write falls in the same cycle as a completion that sets the flag, the flag ends set.
- R10: Launching a command clears the error flag and the error code.
- R11: Reads of unmapped or misaligned offsets (address bits 1:0 not zero) return zero. Writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_wr_en | input | 1 | Host write strobe, one cycle per write |
| hst_addr | input | 8 | Host byte address |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data for `hst_addr`, combinational |
| rsp_req | output | 1 | Command pending toward responder |
| rsp_cmd | output | 32 | Latched command word |
| rsp_sptr | output | 32 | Source pointer word |
| rsp_dptr | output | 32 | Destination pointer word |
| rsp_obuf | output | 128 | Outbound buffer, word 0 in bits 31:0 |
| rsp_wr_en | input | 1 | Responder inbound-buffer write strobe |
| rsp_wr_idx | input | 2 | Inbound word index |
| rsp_wr_data | input | 32 | Inbound write data |
| rsp_done | input | 1 | Responder completion pulse |
| rsp_err | input | 1 | Error flag qualifying `rsp_done` |
| rsp_code | input | 8 | Error code qualifying `rsp_done` |
| irq_o | output | 1 | Level host interrupt, equals interrupt-pending |
| ovf_o | output | 1 | Sticky indicator of a command write made while busy |

## Verification
Most faults in the control state reach a port within one cycle. A stuck or late busy bit shows at once on `rsp_req` and in status bit 0. A wrong enable shows on the next read, as a data word or latched command that holds a value it should have dropped or loses one it should have kept. Errors in the interrupt flag are the exception. They stay hidden until a completion or an acknowledge touches the flag, so the sequence exercises interrupt and polled commands, acknowledge writes with and without bit 2, and an acknowledge that falls in the same cycle as a completion. A stray `rsp_done` and writes made while busy are followed by reads of every word they might have corrupted.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // byte offsets inside the window
  localparam int OFS_CMD  = 'h00;
  localparam int OFS_STS  = 'h04;
  localparam int OFS_SPTR = 'h08;
  localparam int OFS_DPTR = 'h0C;
  localparam int OFS_OBUF = 'h80;
  localparam int OFS_IBUF = 'h90;

  // command and status bit positions
  localparam int CMD_IRQ_BIT  = 8;
  localparam int STS_BUSY     = 0;
  localparam int STS_ERR      = 1;
  localparam int STS_IRQ      = 2;
  localparam int STS_CODE_LSB = 16;
  localparam int CODE_W       = 8;

  typedef struct packed {
    logic              busy;
    logic              err;
    logic              irq;
    logic [CODE_W-1:0] code;
  } mbox_sts_t;

  function automatic logic [31:0] pack_status(input mbox_sts_t s);
    logic [31:0] r;
    r = '0;
    r[STS_BUSY] = s.busy;
    r[STS_ERR]  = s.err;
    r[STS_IRQ]  = s.irq;
    r[STS_CODE_LSB +: CODE_W] = s.code;
    return r;
  endfunction

endpackage

// File: rtl/mbox_wordbank.sv
module mbox_wordbank #(
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [IDX_W-1:0]         idx,
  input  logic [DATA_W-1:0]        wdata,
  output logic [WORDS*DATA_W-1:0]  q_o
);

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic              sel;
    logic [DATA_W-1:0] word_d;
    logic [DATA_W-1:0] word_q;

    assign sel = we && (idx == IDX_W'(w));

    always_comb begin
      word_d = word_q;
      if (sel) word_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q <= '0;
      else if (sel) word_q <= word_d;
    end

    assign q_o[w*DATA_W +: DATA_W] = word_q;
  end

  // R4/R5: the bank keeps every word unless its write enable is high
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q_o));

endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_try,
  input  logic              sts_clr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              rsp_done,
  input  logic              rsp_err,
  input  logic [CODE_W-1:0] rsp_code,
  output mbox_sts_t         sts_o,
  output logic [DATA_W-1:0] cmd_o,
  output logic              ovf_o
);

  logic              busy_q, busy_d;
  logic              err_q, err_d;
  logic              irq_q, irq_d;
  logic              ovf_q, ovf_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic [DATA_W-1:0] cmd_q, cmd_d;
  logic              accept, reject, finish, cmd_en;

  assign accept = launch_try && !busy_q;
  assign reject = launch_try && busy_q;
  assign finish = rsp_done && busy_q;
  assign cmd_en = accept;

  always_comb begin
    busy_d = busy_q;
    err_d  = err_q;
    code_d = code_q;
    irq_d  = irq_q;
    ovf_d  = ovf_q;
    cmd_d  = cmd_q;
    if (accept) begin
      busy_d = 1'b1;
      err_d  = 1'b0;
      code_d = '0;
      cmd_d  = cmd_wdata;
    end
    if (reject) ovf_d = 1'b1;
    if (sts_clr) irq_d = 1'b0;
    if (finish) begin
      busy_d = 1'b0;
      err_d  = rsp_err;
      code_d = rsp_err ? rsp_code : '0;
      if (cmd_q[CMD_IRQ_BIT]) irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      code_q <= '0;
      irq_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      err_q  <= err_d;
      code_q <= code_d;
      irq_q  <= irq_d;
      ovf_q  <= ovf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_en) cmd_q <= cmd_d;
  end

  assign sts_o = '{busy: busy_q, err: err_q, irq: irq_q, code: code_q};
  assign cmd_o = cmd_q;
  assign ovf_o = ovf_q;

  p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_try && !busy_q) |=> (busy_q && cmd_q == $past(cmd_wdata)));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_try && busy_q) |=> (ovf_q && $stable(cmd_q)));

  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);

  p_finish_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && busy_q) |=> (!busy_q && err_q == $past(rsp_err)));

  p_stray_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && !busy_q && !launch_try) |=> ($stable(err_q) && $stable(code_q) && !busy_q));

  p_code_needs_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !err_q |-> (code_q == '0));

  p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(rsp_done && busy_q && cmd_q[CMD_IRQ_BIT]));

  p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr && !(rsp_done && busy_q && cmd_q[CMD_IRQ_BIT])) |=> !irq_q);

  p_launch_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_try && !busy_q) |=> (!err_q && code_q == '0));

endmodule

// File: rtl/mbox_ipc.sv
module mbox_ipc
  import mbox_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int BUF_WORDS = 4,
  localparam int BIDX_W   = $clog2(BUF_WORDS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        hst_wr_en,
  input  logic [ADDR_W-1:0]           hst_addr,
  input  logic [DATA_W-1:0]           hst_wdata,
  output logic [DATA_W-1:0]           hst_rdata,
  output logic                        rsp_req,
  output logic [DATA_W-1:0]           rsp_cmd,
  output logic [DATA_W-1:0]           rsp_sptr,
  output logic [DATA_W-1:0]           rsp_dptr,
  output logic [BUF_WORDS*DATA_W-1:0] rsp_obuf,
  input  logic                        rsp_wr_en,
  input  logic [BIDX_W-1:0]           rsp_wr_idx,
  input  logic [DATA_W-1:0]           rsp_wr_data,
  input  logic                        rsp_done,
  input  logic                        rsp_err,
  input  logic [CODE_W-1:0]           rsp_code,
  output logic                        irq_o,
  output logic                        ovf_o
);

  localparam int BUF_SH = BIDX_W + 2;
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFS_CMD);
  localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(OFS_STS);
  localparam logic [ADDR_W-1:0] A_SPTR = ADDR_W'(OFS_SPTR);
  localparam logic [ADDR_W-1:0] A_DPTR = ADDR_W'(OFS_DPTR);
  localparam logic [ADDR_W-1:0] A_OBUF = ADDR_W'(OFS_OBUF);
  localparam logic [ADDR_W-1:0] A_IBUF = ADDR_W'(OFS_IBUF);

  logic              aligned;
  logic              hit_cmd, hit_sts, hit_sptr, hit_dptr, hit_ob, hit_ib;
  logic [BIDX_W-1:0] bidx;
  logic              busy;
  mbox_sts_t         sts;
  logic [DATA_W-1:0] sts_word;
  logic [2*DATA_W-1:0]         ptr_q;
  logic [BUF_WORDS*DATA_W-1:0] ob_q;
  logic [BUF_WORDS*DATA_W-1:0] ib_q;
  logic [DATA_W-1:0] ob_w [BUF_WORDS];
  logic [DATA_W-1:0] ib_w [BUF_WORDS];
  logic              ptr_we, ob_we, ib_we;

  // address decode, word accesses only
  assign aligned  = (hst_addr[1:0] == 2'b00);
  assign hit_cmd  = aligned && (hst_addr == A_CMD);
  assign hit_sts  = aligned && (hst_addr == A_STS);
  assign hit_sptr = aligned && (hst_addr == A_SPTR);
  assign hit_dptr = aligned && (hst_addr == A_DPTR);
  assign hit_ob   = aligned && (hst_addr[ADDR_W-1:BUF_SH] == A_OBUF[ADDR_W-1:BUF_SH]);
  assign hit_ib   = aligned && (hst_addr[ADDR_W-1:BUF_SH] == A_IBUF[ADDR_W-1:BUF_SH]);
  assign bidx     = hst_addr[BUF_SH-1:2];

  assign busy   = sts.busy;
  assign ptr_we = hst_wr_en && (hit_sptr || hit_dptr) && !busy;
  assign ob_we  = hst_wr_en && hit_ob && !busy;
  assign ib_we  = rsp_wr_en && busy;

  mbox_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch_try (hst_wr_en && hit_cmd),
    .sts_clr    (hst_wr_en && hit_sts && hst_wdata[STS_IRQ]),
    .cmd_wdata  (hst_wdata),
    .rsp_done   (rsp_done),
    .rsp_err    (rsp_err),
    .rsp_code   (rsp_code),
    .sts_o      (sts),
    .cmd_o      (rsp_cmd),
    .ovf_o      (ovf_o)
  );

  mbox_wordbank #(.WORDS(2), .DATA_W(DATA_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ptr_we),
    .idx   (hst_addr[2]),
    .wdata (hst_wdata),
    .q_o   (ptr_q)
  );

  mbox_wordbank #(.WORDS(BUF_WORDS), .DATA_W(DATA_W)) u_obuf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ob_we),
    .idx   (bidx),
    .wdata (hst_wdata),
    .q_o   (ob_q)
  );

  mbox_wordbank #(.WORDS(BUF_WORDS), .DATA_W(DATA_W)) u_ibuf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ib_we),
    .idx   (rsp_wr_idx),
    .wdata (rsp_wr_data),
    .q_o   (ib_q)
  );

  for (genvar w = 0; w < BUF_WORDS; w++) begin : g_unpack
    assign ob_w[w] = ob_q[w*DATA_W +: DATA_W];
    assign ib_w[w] = ib_q[w*DATA_W +: DATA_W];
  end

  assign sts_word = DATA_W'(pack_status(sts));

  always_comb begin
    hst_rdata = '0;
    if (hit_cmd)  hst_rdata = rsp_cmd;
    if (hit_sts)  hst_rdata = sts_word;
    if (hit_sptr) hst_rdata = ptr_q[0 +: DATA_W];
    if (hit_dptr) hst_rdata = ptr_q[DATA_W +: DATA_W];
    if (hit_ob)   hst_rdata = ob_w[bidx];
    if (hit_ib)   hst_rdata = ib_w[bidx];
  end

  assign rsp_req  = busy;
  assign rsp_sptr = ptr_q[0 +: DATA_W];
  assign rsp_dptr = ptr_q[DATA_W +: DATA_W];
  assign rsp_obuf = ob_q;
  assign irq_o    = sts.irq;

  p_req_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_req) |-> $past(hst_wr_en && hit_cmd));

  p_ib_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_wr_en && rsp_req) |=> $stable(ib_q));

  p_ob_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_req |=> $stable(ob_q) && $stable(ptr_q));

endmodule

// File: tb/mbox_ipc_bench.sv
module mbox_ipc_bench;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         hst_wr_en = 1'b0;
  logic [7:0]   hst_addr = '0;
  logic [31:0]  hst_wdata = '0;
  logic [31:0]  hst_rdata;
  logic         rsp_req;
  logic [31:0]  rsp_cmd, rsp_sptr, rsp_dptr;
  logic [127:0] rsp_obuf;
  logic         rsp_wr_en = 1'b0;
  logic [1:0]   rsp_wr_idx = '0;
  logic [31:0]  rsp_wr_data = '0;
  logic         rsp_done = 1'b0;
  logic         rsp_err = 1'b0;
  logic [7:0]   rsp_code = '0;
  logic         irq_o, ovf_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_ipc u_mbox_ipc (
    .clk(clk), .rst_n(rst_n), .hst_wr_en(hst_wr_en), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .rsp_req(rsp_req),
    .rsp_cmd(rsp_cmd), .rsp_sptr(rsp_sptr), .rsp_dptr(rsp_dptr),
    .rsp_obuf(rsp_obuf), .rsp_wr_en(rsp_wr_en), .rsp_wr_idx(rsp_wr_idx),
    .rsp_wr_data(rsp_wr_data), .rsp_done(rsp_done), .rsp_err(rsp_err),
    .rsp_code(rsp_code), .irq_o(irq_o), .ovf_o(ovf_o)
  );

  // behavioural reference model
  logic [31:0] m_cmd, m_sptr, m_dptr;
  logic [31:0] m_ob [4];
  logic [31:0] m_ib [4];
  logic        m_busy, m_err, m_irq, m_ovf;
  logic [7:0]  m_code;

  function automatic logic [31:0] m_status();
    return {8'h00, m_code, 13'h0, m_irq, m_err, m_busy};
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    if (a == 8'h00) return m_cmd;
    if (a == 8'h04) return m_status();
    if (a == 8'h08) return m_sptr;
    if (a == 8'h0C) return m_dptr;
    if (a[7:4] == 4'h8) return m_ob[a[3:2]];
    if (a[7:4] == 4'h9) return m_ib[a[3:2]];
    return 32'h0;
  endfunction

  function automatic string read_tag(input logic [7:0] a);
    if (a[1:0] != 2'b00) return "R11";
    if (a == 8'h00) return "R2";
    if (a == 8'h04) return "R7";
    if (a == 8'h08 || a == 8'h0C || a[7:4] == 4'h8) return "R4";
    if (a[7:4] == 4'h9) return "R5";
    return "R11";
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cmd = '0; m_sptr = '0; m_dptr = '0;
      for (int i = 0; i < 4; i++) begin m_ob[i] = '0; m_ib[i] = '0; end
      m_busy = 0; m_err = 0; m_irq = 0; m_ovf = 0; m_code = '0;
    end else begin
      logic was_busy;
      was_busy = m_busy;
      if (hst_wr_en && hst_addr[1:0] == 2'b00) begin
        if (hst_addr == 8'h00) begin
          if (was_busy) m_ovf = 1;
          else begin m_busy = 1; m_cmd = hst_wdata; m_err = 0; m_code = '0; end
        end else if (hst_addr == 8'h04) begin
          if (hst_wdata[2]) m_irq = 0;
        end else if (!was_busy) begin
          if (hst_addr == 8'h08) m_sptr = hst_wdata;
          if (hst_addr == 8'h0C) m_dptr = hst_wdata;
          if (hst_addr[7:4] == 4'h8) m_ob[hst_addr[3:2]] = hst_wdata;
        end
      end
      if (rsp_wr_en && was_busy) m_ib[rsp_wr_idx] = rsp_wr_data;
      if (rsp_done && was_busy) begin
        m_busy = 0;
        m_err  = rsp_err;
        m_code = rsp_err ? rsp_code : 8'h00;
        if (m_cmd[8]) m_irq = 1;
      end
    end
  end

  task automatic check(input string tag, input string what,
                       input logic [127:0] got, input logic [127:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!finished) begin
      check("R2", "rsp_req", 128'(rsp_req), 128'(m_busy));
      check("R2", "rsp_cmd", 128'(rsp_cmd), 128'(m_cmd));
      check("R4", "rsp_sptr", 128'(rsp_sptr), 128'(m_sptr));
      check("R4", "rsp_dptr", 128'(rsp_dptr), 128'(m_dptr));
      check("R4", "rsp_obuf", rsp_obuf, {m_ob[3], m_ob[2], m_ob[1], m_ob[0]});
      check("R8", "irq_o", 128'(irq_o), 128'(m_irq));
      check("R3", "ovf_o", 128'(ovf_o), 128'(m_ovf));
      check(read_tag(hst_addr), "hst_rdata", 128'(hst_rdata), 128'(m_read(hst_addr)));
    end
  end

  task automatic host_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    hst_wr_en = 1; hst_addr = a; hst_wdata = d;
    @(posedge clk); #1;
    hst_wr_en = 0;
  endtask

  task automatic host_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); #1;
    hst_addr = a;
    #1;
    check(tag, "directed read", 128'(hst_rdata), 128'(exp));
  endtask

  task automatic rsp_fill(input logic [1:0] i, input logic [31:0] d);
    @(negedge clk); #1;
    rsp_wr_en = 1; rsp_wr_idx = i; rsp_wr_data = d;
    @(posedge clk); #1;
    rsp_wr_en = 0;
  endtask

  task automatic rsp_finish(input logic e, input logic [7:0] c);
    @(negedge clk); #1;
    rsp_done = 1; rsp_err = e; rsp_code = c;
    @(posedge clk); #1;
    rsp_done = 0; rsp_err = 0; rsp_code = '0;
  endtask

  task automatic summary();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state
    host_rd(8'h04, 32'h0, "R1");
    host_rd(8'h80, 32'h0, "R1");
    check("R1", "rsp_req", 128'(rsp_req), 128'(0));
    check("R1", "irq_o", 128'(irq_o), 128'(0));

    // R4: pointers and outbound buffer
    host_wr(8'h08, 32'h1111_2222);
    host_wr(8'h0C, 32'h3333_4444);
    for (int i = 0; i < 4; i++) host_wr(8'h80 + 8'(4*i), 32'hA000_0000 + i);
    host_rd(8'h08, 32'h1111_2222, "R4");
    host_rd(8'h0C, 32'h3333_4444, "R4");
    host_rd(8'h8C, 32'hA000_0003, "R4");

    // R7: writes to busy/err/code bits ignored
    host_wr(8'h04, 32'h00FF_0003);
    host_rd(8'h04, 32'h0, "R7");

    // R5: host write and idle responder write to inbound ignored
    host_wr(8'h90, 32'hDEAD_BEEF);
    rsp_fill(2'd1, 32'hBAD0_0001);
    host_rd(8'h90, 32'h0, "R5");
    host_rd(8'h94, 32'h0, "R5");

    // R11: misaligned write does nothing, unmapped read is zero
    host_wr(8'h09, 32'hFFFF_FFFF);
    host_rd(8'h08, 32'h1111_2222, "R11");
    host_rd(8'h40, 32'h0, "R11");
    host_rd(8'h81, 32'h0, "R11");

    // R2: polled launch
    host_wr(8'h00, 32'h0008_302A);
    check("R2", "req after launch", 128'(rsp_req), 128'(1));
    host_rd(8'h04, 32'h0000_0001, "R2");
    host_rd(8'h00, 32'h0008_302A, "R2");

    // R4: writes while busy ignored; R3: second command dropped
    host_wr(8'h08, 32'h5555_5555);
    host_wr(8'h84, 32'h5555_5555);
    host_rd(8'h08, 32'h1111_2222, "R4");
    host_rd(8'h84, 32'hA000_0001, "R4");
    host_wr(8'h00, 32'h0000_0199);
    check("R3", "ovf_o", 128'(ovf_o), 128'(1));
    check("R3", "rsp_cmd", 128'(rsp_cmd), 128'(32'h0008_302A));

    // R5/R6: responder fills, completes without error, code dropped
    for (int i = 0; i < 4; i++) rsp_fill(2'(i), 32'hC0DE_0000 + i);
    rsp_finish(1'b0, 8'h33);
    host_rd(8'h04, 32'h0, "R6");
    check("R8", "polled no irq", 128'(irq_o), 128'(0));
    host_rd(8'h98, 32'hC0DE_0002, "R5");
    host_rd(8'h9C, 32'hC0DE_0003, "R5");

    // R6: stray done ignored
    rsp_finish(1'b1, 8'h77);
    host_rd(8'h04, 32'h0, "R6");

    // R8: interrupt command completing with error
    host_wr(8'h00, 32'h0000_0155);
    rsp_finish(1'b1, 8'h5A);
    host_rd(8'h04, 32'h005A_0006, "R8");
    check("R8", "irq_o", 128'(irq_o), 128'(1));
    check("R3", "ovf sticky", 128'(ovf_o), 128'(1));

    // R9: acknowledge without bit 2, then with it
    host_wr(8'h04, 32'h0000_0003);
    host_rd(8'h04, 32'h005A_0006, "R9");
    host_wr(8'h04, 32'h0000_0004);
    host_rd(8'h04, 32'h005A_0002, "R9");
    check("R9", "irq_o cleared", 128'(irq_o), 128'(0));

    // R10: launch clears error and code
    host_wr(8'h00, 32'h0000_0001);
    host_rd(8'h04, 32'h0000_0001, "R10");
    rsp_finish(1'b0, 8'h00);
    host_rd(8'h04, 32'h0, "R10");

    // R9: acknowledge in the same cycle as a setting completion
    host_wr(8'h00, 32'h0000_0100);
    @(negedge clk); #1;
    hst_wr_en = 1; hst_addr = 8'h04; hst_wdata = 32'h4;
    rsp_done = 1; rsp_err = 0;
    @(posedge clk); #1;
    hst_wr_en = 0; rsp_done = 0;
    host_rd(8'h04, 32'h0000_0004, "R9");
    host_wr(8'h04, 32'h0000_0004);
    host_rd(8'h04, 32'h0, "R9");

    repeat (2) @(posedge clk);
    summary();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      summary();
    end
  end

endmodule